// File: doc/BRIEF.md
# Flash Page Program Buffer

This block holds one full flash page (128 bytes) and writes it to a serial NOR flash with a single command. Software first sets a mode bit that moves a shared buffer from read-prefetch use to page-program use. It then waits until the mode readback shows the new value, loads the page as 32 words through one data port, and issues the program command. The engine sends a write-enable frame. It then sends a page-program frame that carries a 24-bit address and the whole page, and polls the flash status until the flash is no longer busy.

The engine drives SPI mode 0: the clock idles low, data goes out most significant bit first and changes while the clock is low, and the flash data is sampled as the clock falls. One serial bit takes two system clocks. Chip select stays high for a set number of cycles between frames.

Top module: `ppb_page_program`

## Requirements
- R1: After reset, mode_ack is 0 (read prefetch), busy is 0, spi_cs_n is 1 and spi_sclk is 0.
- R2: A write with reg_sel 0 requests the buffer mode from reg_wdata bit 0 (0 = read prefetch, 1 = page program). mode_ack takes the requested value exactly SWITCH_CYC clock edges after the write edge. Mode writes made while busy is 1 are ignored.
- R3: A write with reg_sel 1 stores reg_wdata as the next buffer word, but only while mode_ack is 1 and busy is 0. Writes after the 32nd word are dropped until the fill pointer is reset.
- R4: Byte 4k+j of the page (j = 0..3) is bits 8j+7:8j of the k-th stored word.
- R5: The fill pointer returns to zero when mode_ack changes to 1 and on every accepted program command.
- R6: A write with reg_sel 2 and reg_wdata bit 4 set is a program command. When mode_ack is 1 and 32 words are stored, busy is 1 from the next cycle until the sequence ends.
- R7: The command sends a one-byte frame 0x06. It then sends one frame with 0x02, page_addr bits 23:16, 15:8 and 7:0, and the 128 page bytes in increasing order. Every byte goes out MSB first. spi_sclk is high only while spi_cs_n is low.
- R8: After programming, the engine sends two-byte frames of 0x05 followed by a read byte. It repeats them until bit 0 of the read byte is 0, then clears busy.
- R9: A program command given while mode_ack is 0, or with fewer than 32 words stored, causes no SPI activity, and busy stays 0.
- R10: Data writes and command writes made while busy is 1 have no effect.
- R11: Between frames of one sequence, spi_cs_n stays high for at least GAP_CYC clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 mode, 1 data, 2 command |
| reg_wdata | input | 32 | Write data |
| page_addr | input | 24 | Flash address of the page, sampled at command |
| mode_ack | output | 1 | Mode that is currently in effect |
| busy | output | 1 | Program sequence in progress |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The collision of interest is between the end of a program sequence and a register write. Two things happen close together: the final status poll clears busy, and a mode write, a data write or a repeated command arrives. The bench issues a mode write on every cycle while busy is high, plus one stray data word and one stray command. It then checks that mode_ack has not moved. It also checks that a later 31-word fill still counts as short, which shows that the stray word was dropped. Finally, the first mode write after busy falls must take effect on schedule.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
    localparam int DEF_PAGE_BYTES = 128;
    localparam int DEF_WORD_W     = 32;
    localparam int DEF_ADDR_W     = 24;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CMD  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_STAT = 8'h05;
    localparam int         CMD_PROG_BIT = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WREN, ST_GAP_A, ST_PROG, ST_GAP_B, ST_POLL, ST_GAP_C
    } seq_e;

    function automatic logic is_frame_state(seq_e s);
        return (s == ST_WREN) || (s == ST_PROG) || (s == ST_POLL);
    endfunction
endpackage

// File: rtl/ppb_byte_shifter.sv
module ppb_byte_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [BITS-1:0] tx,
    input  logic            miso,
    output logic            sclk,
    output logic            mosi,
    output logic            done,
    output logic            rx_last
);
    localparam int CNT_W = $clog2(BITS);

    logic             active, phase;
    logic [CNT_W-1:0] cnt;
    logic [BITS-1:0]  sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            phase   <= 1'b0;
            cnt     <= '0;
            sh      <= '0;
            sclk    <= 1'b0;
            done    <= 1'b0;
            rx_last <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                phase  <= 1'b0;
                cnt    <= '0;
                sh     <= tx;
            end else if (active) begin
                if (!phase) begin
                    sclk  <= 1'b1;
                    phase <= 1'b1;
                end else begin
                    sclk    <= 1'b0;
                    phase   <= 1'b0;
                    rx_last <= miso;
                    sh      <= {sh[BITS-2:0], 1'b0};
                    if (cnt == CNT_W'(BITS - 1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    assign mosi = sh[BITS-1];

    assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
        start |-> !active);
    assert_done_ends_clock_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !sclk);
endmodule

// File: rtl/ppb_page_store.sv
module ppb_page_store #(
    parameter int WORDS  = 32,
    parameter int WORD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 load,
    input  logic [WORD_W-1:0]    wdata,
    input  logic [$clog2(WORDS*(WORD_W/8))-1:0] rd_idx,
    output logic [7:0]           rd_byte,
    output logic                 full
);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int LANE_W     = $clog2(WORD_BYTES);
    localparam int PTR_W      = $clog2(WORDS);
    localparam int CNT_W      = $clog2(WORDS + 1);
    localparam int BIDX_W     = $clog2(WORDS * WORD_BYTES);

    logic [WORD_W-1:0] mem [WORDS];
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] cur_word;
    logic [7:0]        lanes [WORD_BYTES];

    assign full = (cnt == CNT_W'(WORDS));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (load && !full) begin
            mem[cnt[PTR_W-1:0]] <= wdata;
            cnt <= cnt + 1'b1;
        end
    end

    assign cur_word = mem[rd_idx[BIDX_W-1:LANE_W]];

    for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
        assign lanes[l] = cur_word[l*8 +: 8];
    end

    assign rd_byte = lanes[rd_idx[LANE_W-1:0]];

    assert_fill_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(WORDS));
    assert_full_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (full && !clr) |=> full);
endmodule

// File: rtl/ppb_page_program.sv
module ppb_page_program
    import ppb_pkg::*;
#(
    parameter int PAGE_BYTES = DEF_PAGE_BYTES,
    parameter int WORD_W     = DEF_WORD_W,
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int SWITCH_CYC = 4,
    parameter int GAP_CYC    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] page_addr,
    output logic              mode_ack,
    output logic              busy,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int WORDS      = PAGE_BYTES / (WORD_W / 8);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int LAST_PROG  = ADDR_BYTES + PAGE_BYTES;
    localparam int IDX_W      = $clog2(LAST_PROG + 1);
    localparam int BIDX_W     = $clog2(PAGE_BYTES);
    localparam int SW_W       = $clog2(SWITCH_CYC + 1);
    localparam int GAP_W      = $clog2(GAP_CYC + 1);

    reg_sel_e          sel;
    seq_e              state;
    logic              mode_req, mode_ack_q, pend, busy_q;
    logic [SW_W-1:0]   sw_cnt;
    logic [GAP_W-1:0]  gap_cnt;
    logic [IDX_W-1:0]  idx;
    logic              launched, stat_busy;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_mode, wr_data_ok, wr_cmd, enter_prog, switch_now, full;
    logic              sh_start, sh_done, sh_rx;
    logic [7:0]        tx_byte, store_byte;
    logic [BIDX_W-1:0] rd_idx;

    assign sel        = reg_sel_e'(reg_sel);
    assign wr_mode    = reg_we && sel == SEL_MODE && !busy_q;
    assign wr_data_ok = reg_we && sel == SEL_DATA && !busy_q && mode_ack_q;
    assign wr_cmd     = reg_we && sel == SEL_CMD && !busy_q && reg_wdata[CMD_PROG_BIT];
    assign switch_now = pend && !busy_q && sw_cnt == SW_W'(SWITCH_CYC - 1);
    assign enter_prog = switch_now && mode_req && !mode_ack_q;

    // mode switch with delayed acknowledge
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_req   <= 1'b0;
            mode_ack_q <= 1'b0;
            pend       <= 1'b0;
            sw_cnt     <= '0;
        end else if (wr_mode) begin
            mode_req <= reg_wdata[0];
            pend     <= 1'b1;
            sw_cnt   <= '0;
        end else if (switch_now) begin
            mode_ack_q <= mode_req;
            pend       <= 1'b0;
        end else if (pend && !busy_q) begin
            sw_cnt <= sw_cnt + 1'b1;
        end
    end

    ppb_page_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst(rst), .clr(wr_cmd || enter_prog), .load(wr_data_ok),
        .wdata(reg_wdata), .rd_idx(rd_idx), .rd_byte(store_byte), .full(full)
    );

    assign rd_idx = BIDX_W'(idx - IDX_W'(1 + ADDR_BYTES));

    // byte selection for the current frame position
    always_comb begin
        tx_byte = 8'h00;
        unique case (state)
            ST_WREN: tx_byte = OP_WREN;
            ST_PROG: begin
                if (idx == '0)
                    tx_byte = OP_PROG;
                else if (idx <= IDX_W'(ADDR_BYTES))
                    tx_byte = addr_q[(ADDR_BYTES - int'(idx)) * 8 +: 8];
                else
                    tx_byte = store_byte;
            end
            ST_POLL: tx_byte = (idx == '0) ? OP_STAT : 8'h00;
            default: tx_byte = 8'h00;
        endcase
    end

    assign sh_start = is_frame_state(state) && !launched;

    ppb_byte_shifter #(.BITS(8)) u_shift (
        .clk(clk), .rst(rst), .start(sh_start), .tx(tx_byte), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .done(sh_done), .rx_last(sh_rx)
    );

    // command sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            busy_q    <= 1'b0;
            idx       <= '0;
            gap_cnt   <= '0;
            launched  <= 1'b0;
            stat_busy <= 1'b0;
            addr_q    <= '0;
        end else begin
            if (sh_start) launched <= 1'b1;
            if (sh_done)  launched <= 1'b0;
            unique case (state)
                ST_IDLE: if (wr_cmd && mode_ack_q && full) begin
                    state  <= ST_WREN;
                    busy_q <= 1'b1;
                    addr_q <= page_addr;
                    idx    <= '0;
                end
                ST_WREN: if (sh_done) begin
                    state   <= ST_GAP_A;
                    gap_cnt <= '0;
                end
                ST_PROG: if (sh_done) begin
                    if (idx == IDX_W'(LAST_PROG)) begin
                        state   <= ST_GAP_B;
                        gap_cnt <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_POLL: if (sh_done) begin
                    if (idx != '0) begin
                        stat_busy <= sh_rx;
                        state     <= ST_GAP_C;
                        gap_cnt   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: begin
                    if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
                        idx <= '0;
                        if (state == ST_GAP_A)
                            state <= ST_PROG;
                        else if (state == ST_GAP_B || stat_busy)
                            state <= ST_POLL;
                        else begin
                            state  <= ST_IDLE;
                            busy_q <= 1'b0;
                        end
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign spi_cs_n = !is_frame_state(state);
    assign mode_ack = mode_ack_q;
    assign busy     = busy_q;

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> spi_cs_n);
    assert_sclk_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> !spi_cs_n);
    assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mode_ack));
    assert_start_needs_mode_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> mode_ack);
    assert_gap_R11: assert property (@(posedge clk) disable iff (rst)
        ((GAP_CYC > 1) && $rose(spi_cs_n)) |=> spi_cs_n);
endmodule

// File: tb/sim_ppb_page_program.sv
`timescale 1ns/1ps
module sim_ppb_page_program;
    localparam int SW  = 4;
    localparam int GAP = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd3;
    logic [31:0] reg_wdata = '0;
    logic [23:0] page_addr = '0;
    logic        mode_ack, busy, spi_sclk, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    ppb_page_program #(.SWITCH_CYC(SW), .GAP_CYC(GAP)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .page_addr(page_addr), .mode_ack(mode_ack),
        .busy(busy), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // flash model
    logic [7:0] fb [0:255];
    logic [7:0] pg [0:255];
    logic [7:0] cur = '0, stat = '0;
    int nb = 0, bitc = 0, frames = 0, phase = 0, poll_seen = 0, busy_polls = 0;
    int order_err = 0, bad_frame = 0, prog_len = 0, hi_run = 0, min_run = 1000;

    always @(negedge spi_cs_n) begin
        nb = 0; bitc = 0;
        stat = (poll_seen < busy_polls) ? 8'hC3 : 8'h3C;
    end
    always @(posedge spi_sclk) begin
        cur = {cur[6:0], spi_mosi};
        bitc++;
        if (bitc % 8 == 0) begin
            if (nb < 256) fb[nb] = cur;
            nb++;
        end
    end
    always @(negedge spi_sclk)
        if (!spi_cs_n && nb >= 1 && fb[0] == 8'h05) spi_miso <= stat[7 - (bitc % 8)];
    always @(posedge spi_cs_n) begin
        if (nb > 0) begin
            frames++;
            case (fb[0])
                8'h06: begin
                    if (nb != 1) bad_frame++;
                    if (phase == 0) phase = 1; else order_err++;
                end
                8'h02: begin
                    if (phase == 1) phase = 2; else order_err++;
                    prog_len = nb;
                    for (int i = 0; i < 256; i++) pg[i] = fb[i];
                end
                8'h05: begin
                    if (phase == 2) poll_seen++; else order_err++;
                    if (nb != 2) bad_frame++;
                end
                default: bad_frame++;
            endcase
        end
    end
    always @(posedge clk) begin
        if (spi_cs_n) hi_run++;
        else begin
            if (hi_run > 0 && hi_run < min_run) min_run = hi_run;
            hi_run = 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_sel = 2'd3;
    endtask

    logic [31:0] words [0:39];

    function automatic logic [7:0] exp_byte(int b);
        return words[b / 4][(b % 4) * 8 +: 8];
    endfunction

    task automatic set_mode(input bit m);
        wr(2'd0, {31'd0, m});
        repeat (SW) @(negedge clk);
    endtask

    task automatic load_words(input int n);
        for (int i = 0; i < n; i++) wr(2'd1, words[i]);
    endtask

    task automatic wait_idle(input bit spam);
        int guard = 0;
        while (busy && guard < 20000) begin
            if (spam) begin
                reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 32'd0;
                if (guard == 40) reg_sel = 2'd1;
                if (guard == 80) begin reg_sel = 2'd2; reg_wdata = 32'h10; end
            end
            @(negedge clk);
            reg_we = 1'b0; reg_sel = 2'd3;
            guard++;
        end
        check(guard < 20000, "R8", "busy clears", guard, 0);
    endtask

    task automatic program_page(input logic [23:0] a, input int bp, input bit spam);
        int mism = 0;
        busy_polls = bp; phase = 0; poll_seen = 0; order_err = 0;
        bad_frame = 0; prog_len = 0; min_run = 1000; hi_run = 1000;
        page_addr = a;
        wr(2'd2, 32'h10);
        check(busy == 1'b1, "R6", "busy after command", int'(busy), 1);
        wait_idle(spam);
        check(order_err == 0 && phase == 2, "R7", "frame order", order_err, 0);
        check(bad_frame == 0, "R7", "frame shapes", bad_frame, 0);
        check(prog_len == 132, "R7", "program frame length", prog_len, 132);
        check({pg[1], pg[2], pg[3]} == a, "R7", "address bytes",
              int'({pg[1], pg[2], pg[3]}), int'(a));
        for (int b = 0; b < 128; b++) if (pg[b + 4] != exp_byte(b)) mism++;
        check(mism == 0, "R4", "page byte mismatches", mism, 0);
        check(poll_seen == bp + 1, "R8", "status polls", poll_seen, bp + 1);
        check(min_run >= GAP, "R11", "cs high between frames", min_run, GAP);
        check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R8", "bus idle after",
              int'(spi_cs_n), 1);
    endtask

    task automatic expect_no_activity(input string req);
        int f0 = frames;
        wr(2'd2, 32'h10);
        check(busy == 1'b0, req, "busy stays low", int'(busy), 0);
        repeat (50) @(negedge clk);
        check(frames == f0 && spi_cs_n, req, "no SPI frames", frames - f0, 0);
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(mode_ack == 1'b0, "R1", "mode_ack", int'(mode_ack), 0);
        check(busy == 1'b0, "R1", "busy", int'(busy), 0);
        check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1", "bus idle", int'(spi_cs_n), 1);

        // R2 switch timing
        wr(2'd0, 32'd1);
        repeat (SW - 1) @(negedge clk);
        check(mode_ack == 1'b0, "R2", "ack before delay", int'(mode_ack), 0);
        @(negedge clk);
        check(mode_ack == 1'b1, "R2", "ack after delay", int'(mode_ack), 1);

        // first page, with collisions during busy (R10, R2)
        for (int i = 0; i < 40; i++) words[i] = $urandom;
        load_words(32);
        program_page(24'h12AB40, 2, 1'b1);
        check(mode_ack == 1'b1, "R10", "mode write during busy ignored", int'(mode_ack), 1);
        for (int i = 0; i < 40; i++) words[i] = $urandom;
        load_words(31);
        expect_no_activity("R10");

        // R5 pointer reset by command: 20 + 12 words is still short
        load_words(20);
        expect_no_activity("R9");
        load_words(12);
        expect_no_activity("R5");

        // R5 pointer reset on entering program mode
        load_words(10);
        set_mode(1'b0);
        set_mode(1'b1);
        load_words(22);
        expect_no_activity("R5");

        // R3 overflow: 40 words, only first 32 used
        for (int i = 0; i < 40; i++) words[i] = $urandom;
        load_words(40);
        program_page(24'hFFFF80, 0, 1'b0);

        // R9 read-prefetch mode: data ignored and command idle
        set_mode(1'b0);
        check(mode_ack == 1'b0, "R2", "back to prefetch", int'(mode_ack), 0);
        load_words(32);
        expect_no_activity("R9");
        set_mode(1'b1);
        expect_no_activity("R3");

        // random pages
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 40; i++) words[i] = $urandom;
            load_words(32);
            program_page(24'($urandom), int'($urandom % 4), 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule